// File: doc/BRIEF.md
# Configuration memory read sequencer

This block is the read side of a configuration store that feeds an FPGA during configuration. A small on-chip ROM holds four design revisions. Each revision has its own start and end address. An address counter walks through the selected revision and presents the stored data in one of two ways. In parallel mode it drives a whole byte per step. In serial mode it drives one bit per step on bit 0, most significant bit first.

The counter steps only on a qualified edge of the sequencing clock. That clock is either an external clock input, synchronised into the system clock domain, or a divided copy of the system clock, chosen by a parameter. Several control inputs can stop stepping:

- a chip enable, which puts the block into standby;
- a fixed-polarity output-enable/reset;
- a busy input, which counts in parallel mode only;
- a configuration pulse.

A rising edge on the configuration pulse samples the revision select and reloads the counter. Tri-state is modelled by separate output-enable signals for bit 0 and for bits 1 to 7, and by one for the clock monitor output.

Top module: `cfg_rom_reader`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `done`, `data0_oe`, `data_hi_oe` and `clk_out_oe` are 0 when `chip_en_n` is held high. Reset selects revision 0.
- R2: When `par_mode`=1, `chip_en_n`=0, `oe_rst_n`=1, `cfg_pulse`=1 and `busy`=0, each rising edge of `cfg_clk_in` advances the address by exactly one. Each level of `cfg_clk_in` must last at least 3 clk cycles. The new byte is on `data_out` within 12 clk cycles of the edge.
- R3: In parallel mode, `busy`=1 stops the address from advancing. In serial mode `busy` is ignored.
- R4: While `cfg_pulse` is low, the address and the bit position do not change.
- R5: A rising edge of `cfg_pulse` samples `rev_sel`, loads that revision's start address and clears `done`. The start addresses are 0, 16, 32 and 48 for `rev_sel` 0 to 3.
- R6: While `oe_rst_n` is low, the counter is held at the start address of the latched revision, `done` is 0, and every output enable is 0 one cycle later.
- R7: While `chip_en_n` is high, the block behaves in the same way (standby). Clock edges received in standby are lost, so data restarts at the revision start when the block is enabled again.
- R8: In serial mode `data_hi_oe` is 0, and `data_out[0]` carries the current byte MSB first, one bit per qualified edge. After bit 0 of a byte, the next byte follows.
- R9: In parallel mode `data0_oe` and `data_hi_oe` are both 1 when enabled. `data_out` equals the stored byte, which is (29*a + 7) mod 256 at address a.
- R10: At the end address of the latched revision (15, 31, 47 or 63), the next qualified edge sets `done`. From then on the address and data hold until a reload, standby or output-enable/reset.
- R11: With `CLK_SRC_INT`=1, the counter steps on every `OSC_DIV`-th system clock with no activity on `cfg_clk_in`. It reaches `done` at the end of revision 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_in | input | 1 | External sequencing clock, sampled in the clk domain |
| chip_en_n | input | 1 | Chip enable, active low; high means standby |
| oe_rst_n | input | 1 | Output enable and counter reset, low holds reset |
| busy | input | 1 | Stall request from the FPGA, honoured in parallel mode |
| cfg_pulse | input | 1 | Configuration pulse; low stalls, rising edge reloads |
| rev_sel | input | REV_W | Design revision select |
| par_mode | input | 1 | 1 = byte-wide parallel, 0 = serial on bit 0 |
| data_out | output | 8 | Read data |
| data0_oe | output | 1 | Output enable of data bit 0 |
| data_hi_oe | output | 1 | Output enable of data bits 1 to 7 |
| clk_out | output | 1 | Copy of the selected sequencing clock |
| clk_out_oe | output | 1 | Output enable of clk_out |
| done | output | 1 | End address of the revision reached |

## Verification
The hardest state to reach from the ports is a finished revision that then meets a stall and a reload. To get there, the stimulus has to step through a full revision of 16 bytes before `done` rises. It then applies further clock edges to show that nothing moves. A configuration pulse edge to another revision must then clear `done` and restart at the new start address. The serial walk is run with `busy` held high, so it also shows that `busy` has no effect in that mode. It crosses a byte boundary to check the MSB-first order across two bytes. A second instance built with the internal divider shows that the counter steps with no external clock at all.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  localparam int BYTE_W = 8;

  typedef logic [2:0] bitpos_t;

  // Stored pattern: byte at address a is (29*a + 7) mod 256.
  function automatic logic [BYTE_W-1:0] seed_byte(input int a);
    return BYTE_W'((a * 29 + 7) % 256);
  endfunction

endpackage

// File: rtl/cfgrd_tick_gen.sv
module cfgrd_tick_gen #(
  parameter bit CLK_SRC_INT = 1'b0,
  parameter int OSC_DIV     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  output logic tick,
  output logic clk_mon
);
  localparam int DIV_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;

  logic [2:0] sync_q;
  logic       ext_tick_q;
  logic       osc_tick;
  logic       osc_mon;

  // Synchroniser plus rising-edge detector for the external clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      ext_tick_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[1:0], ext_clk};
      ext_tick_q <= sync_q[1] & ~sync_q[2];
    end
  end

  generate
    if (CLK_SRC_INT) begin : g_osc
      logic [DIV_W-1:0] div_cnt;
      logic             osc_tick_q;
      logic             osc_mon_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_cnt    <= '0;
          osc_tick_q <= 1'b0;
          osc_mon_q  <= 1'b0;
        end else begin
          if (div_cnt == DIV_W'(OSC_DIV - 1)) begin
            div_cnt    <= '0;
            osc_tick_q <= 1'b1;
          end else begin
            div_cnt    <= div_cnt + 1'b1;
            osc_tick_q <= 1'b0;
          end
          osc_mon_q <= (div_cnt < DIV_W'(OSC_DIV / 2));
        end
      end
      assign osc_tick = osc_tick_q;
      assign osc_mon  = osc_mon_q;
    end else begin : g_ext
      assign osc_tick = 1'b0;
      assign osc_mon  = 1'b0;
    end
  endgenerate

  assign tick    = CLK_SRC_INT ? osc_tick : ext_tick_q;
  assign clk_mon = CLK_SRC_INT ? osc_mon  : sync_q[2];

endmodule

// File: rtl/cfgrd_addr_seq.sv
module cfgrd_addr_seq #(
  parameter int                      ADDR_W    = 6,
  parameter int                      NUM_REV   = 4,
  parameter int                      REV_W     = 2,
  parameter logic [NUM_REV*ADDR_W-1:0] REV_START = '0,
  parameter logic [NUM_REV*ADDR_W-1:0] REV_END   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              chip_en_n,
  input  logic              oe_rst_n,
  input  logic              busy,
  input  logic              cfg_pulse,
  input  logic [REV_W-1:0]  rev_sel,
  input  logic              par_mode,
  output logic [ADDR_W-1:0] addr_q,
  output cfgrd_pkg::bitpos_t bit_q,
  output logic              done_q,
  output logic              pulse_rise,
  output logic [REV_W-1:0]  rev_q
);
  logic pulse_d;
  logic hold;
  logic go;
  logic at_end;

  function automatic logic [ADDR_W-1:0] start_of(input logic [REV_W-1:0] r);
    return REV_START[r*ADDR_W +: ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] end_of(input logic [REV_W-1:0] r);
    return REV_END[r*ADDR_W +: ADDR_W];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pulse_d <= 1'b1;
    else     pulse_d <= cfg_pulse;
  end

  assign pulse_rise = cfg_pulse & ~pulse_d;
  assign hold       = chip_en_n | ~oe_rst_n;
  assign go         = tick & ~hold & cfg_pulse & ~(par_mode & busy) & ~done_q;
  assign at_end     = (addr_q == end_of(rev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      rev_q  <= '0;
      addr_q <= start_of('0);
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (pulse_rise) begin
      rev_q  <= rev_sel;
      addr_q <= start_of(rev_sel);
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (hold) begin
      addr_q <= start_of(rev_q);
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (go) begin
      if (!par_mode && bit_q != 3'd7) begin
        bit_q <= bit_q + 1'b1;
      end else if (at_end) begin
        done_q <= 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
        bit_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/cfgrd_rom.sv
module cfgrd_rom #(
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic [ADDR_W-1:0]             addr,
  output logic [cfgrd_pkg::BYTE_W-1:0]  rd_q
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [cfgrd_pkg::BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = cfgrd_pkg::seed_byte(i);
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
  end

endmodule

// File: rtl/cfgrd_out_stage.sv
module cfgrd_out_stage (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [cfgrd_pkg::BYTE_W-1:0]  rd_byte,
  input  cfgrd_pkg::bitpos_t            bit_pos,
  input  logic                          par_mode,
  input  logic                          chip_en_n,
  input  logic                          oe_rst_n,
  input  logic                          clk_mon,
  output logic [cfgrd_pkg::BYTE_W-1:0]  data_out,
  output logic                          data0_oe,
  output logic                          data_hi_oe,
  output logic                          clk_out,
  output logic                          clk_out_oe
);
  cfgrd_pkg::bitpos_t bit_d;
  logic               live;

  assign live = ~chip_en_n & oe_rst_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_d      <= '0;
      data_out   <= '0;
      data0_oe   <= 1'b0;
      data_hi_oe <= 1'b0;
      clk_out    <= 1'b0;
      clk_out_oe <= 1'b0;
    end else begin
      bit_d      <= bit_pos;
      data_out   <= par_mode ? rd_byte
                             : {{(cfgrd_pkg::BYTE_W-1){1'b0}}, rd_byte[3'd7 - bit_d]};
      data0_oe   <= live;
      data_hi_oe <= live & par_mode;
      clk_out    <= clk_mon;
      clk_out_oe <= live;
    end
  end

endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader #(
  parameter int                        ADDR_W      = 6,
  parameter int                        NUM_REV     = 4,
  parameter logic [NUM_REV*ADDR_W-1:0] REV_START   = {6'd48, 6'd32, 6'd16, 6'd0},
  parameter logic [NUM_REV*ADDR_W-1:0] REV_END     = {6'd63, 6'd47, 6'd31, 6'd15},
  parameter bit                        CLK_SRC_INT = 1'b0,
  parameter int                        OSC_DIV     = 4,
  localparam int                       REV_W       = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_clk_in,
  input  logic             chip_en_n,
  input  logic             oe_rst_n,
  input  logic             busy,
  input  logic             cfg_pulse,
  input  logic [REV_W-1:0] rev_sel,
  input  logic             par_mode,
  output logic [7:0]       data_out,
  output logic             data0_oe,
  output logic             data_hi_oe,
  output logic             clk_out,
  output logic             clk_out_oe,
  output logic             done
);
  logic               tick;
  logic               clk_mon;
  logic [ADDR_W-1:0]  addr_q;
  cfgrd_pkg::bitpos_t bit_q;
  logic               done_q;
  logic               pulse_rise;
  logic [REV_W-1:0]   rev_q;
  logic [7:0]         rd_byte;

  cfgrd_tick_gen #(
    .CLK_SRC_INT(CLK_SRC_INT),
    .OSC_DIV    (OSC_DIV)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .ext_clk(cfg_clk_in),
    .tick   (tick),
    .clk_mon(clk_mon)
  );

  cfgrd_addr_seq #(
    .ADDR_W   (ADDR_W),
    .NUM_REV  (NUM_REV),
    .REV_W    (REV_W),
    .REV_START(REV_START),
    .REV_END  (REV_END)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .chip_en_n (chip_en_n),
    .oe_rst_n  (oe_rst_n),
    .busy      (busy),
    .cfg_pulse (cfg_pulse),
    .rev_sel   (rev_sel),
    .par_mode  (par_mode),
    .addr_q    (addr_q),
    .bit_q     (bit_q),
    .done_q    (done_q),
    .pulse_rise(pulse_rise),
    .rev_q     (rev_q)
  );

  cfgrd_rom #(
    .ADDR_W(ADDR_W)
  ) u_rom (
    .clk (clk),
    .addr(addr_q),
    .rd_q(rd_byte)
  );

  cfgrd_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_byte   (rd_byte),
    .bit_pos   (bit_q),
    .par_mode  (par_mode),
    .chip_en_n (chip_en_n),
    .oe_rst_n  (oe_rst_n),
    .clk_mon   (clk_mon),
    .data_out  (data_out),
    .data0_oe  (data0_oe),
    .data_hi_oe(data_hi_oe),
    .clk_out   (clk_out),
    .clk_out_oe(clk_out_oe)
  );

  assign done = done_q;

endmodule

// File: rtl/cfgrd_checker.sv
module cfgrd_checker #(
  parameter int                        ADDR_W    = 6,
  parameter int                        NUM_REV   = 4,
  parameter int                        REV_W     = 2,
  parameter logic [NUM_REV*ADDR_W-1:0] REV_START = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_en_n,
  input logic              oe_rst_n,
  input logic              busy,
  input logic              cfg_pulse,
  input logic [REV_W-1:0]  rev_sel,
  input logic              par_mode,
  input logic              data0_oe,
  input logic              data_hi_oe,
  input logic [ADDR_W-1:0] addr_q,
  input logic [2:0]        bit_q,
  input logic              done_q,
  input logic              pulse_rise,
  input logic [REV_W-1:0]  rev_q
);
  logic [ADDR_W-1:0] latched_start;
  logic [ADDR_W-1:0] sel_start;
  logic              live;

  assign latched_start = REV_START[rev_q*ADDR_W +: ADDR_W];
  assign sel_start     = REV_START[rev_sel*ADDR_W +: ADDR_W];
  assign live          = ~chip_en_n & oe_rst_n;

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!pulse_rise && live) |=>
      (addr_q == $past(addr_q)) || (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  assert_busy_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (par_mode && busy && live && !pulse_rise) |=> ($stable(addr_q) && $stable(done_q)));

  assert_pulse_low_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pulse && live) |=> ($stable(addr_q) && $stable(bit_q)));

  assert_reload_start_R5: assert property (@(posedge clk) disable iff (rst)
    pulse_rise |=> ((addr_q == $past(sel_start)) && !done_q));

  assert_oe_reset_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!oe_rst_n && !pulse_rise) |=> ((addr_q == $past(latched_start)) && !done_q && !data0_oe));

  assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    chip_en_n |=> (!data0_oe && !data_hi_oe));

  assert_serial_hi_off_R8: assert property (@(posedge clk) disable iff (rst)
    !par_mode |=> !data_hi_oe);

  assert_done_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (done_q && live && !pulse_rise) |=> (done_q && $stable(addr_q)));

endmodule

bind cfg_rom_reader cfgrd_checker #(
  .ADDR_W   (ADDR_W),
  .NUM_REV  (NUM_REV),
  .REV_W    (REV_W),
  .REV_START(REV_START)
) u_cfgrd_checker (
  .clk       (clk),
  .rst       (rst),
  .chip_en_n (chip_en_n),
  .oe_rst_n  (oe_rst_n),
  .busy      (busy),
  .cfg_pulse (cfg_pulse),
  .rev_sel   (rev_sel),
  .par_mode  (par_mode),
  .data0_oe  (data0_oe),
  .data_hi_oe(data_hi_oe),
  .addr_q    (addr_q),
  .bit_q     (bit_q),
  .done_q    (done_q),
  .pulse_rise(pulse_rise),
  .rev_q     (rev_q)
);

// File: tb/cfg_rom_reader_bench.sv
module cfg_rom_reader_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_clk_in = 1'b0;
  logic       chip_en_n = 1'b1;
  logic       oe_rst_n = 1'b1;
  logic       busy = 1'b0;
  logic       cfg_pulse = 1'b1;
  logic [1:0] rev_sel = 2'd0;
  logic       par_mode = 1'b1;
  logic [7:0] data_out;
  logic       data0_oe, data_hi_oe, clk_out, clk_out_oe, done;

  logic [7:0] o_data;
  logic       o_oe0, o_oehi, o_clk, o_clk_oe, o_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  cfg_rom_reader u_cfg_rom_reader (
    .clk(clk), .rst(rst), .cfg_clk_in(cfg_clk_in), .chip_en_n(chip_en_n),
    .oe_rst_n(oe_rst_n), .busy(busy), .cfg_pulse(cfg_pulse), .rev_sel(rev_sel),
    .par_mode(par_mode), .data_out(data_out), .data0_oe(data0_oe),
    .data_hi_oe(data_hi_oe), .clk_out(clk_out), .clk_out_oe(clk_out_oe), .done(done)
  );

  cfg_rom_reader #(.CLK_SRC_INT(1'b1), .OSC_DIV(4)) u_cfg_rom_reader_osc (
    .clk(clk), .rst(rst), .cfg_clk_in(1'b0), .chip_en_n(1'b0),
    .oe_rst_n(1'b1), .busy(1'b0), .cfg_pulse(1'b1), .rev_sel(2'd0),
    .par_mode(1'b1), .data_out(o_data), .data0_oe(o_oe0),
    .data_hi_oe(o_oehi), .clk_out(o_clk), .clk_out_oe(o_clk_oe), .done(o_done)
  );

  // Reference model state, built from the requirements.
  int m_addr = 0;
  int m_bit  = 0;
  bit m_done = 1'b0;
  int m_rev  = 0;

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 29 + 7) % 256);
  endfunction
  function automatic int rev_start(input int r);
    return r * 16;
  endfunction
  function automatic int rev_end(input int r);
    return r * 16 + 15;
  endfunction

  typedef struct {
    logic [7:0] data;
    logic [7:0] mask;
    logic       oe0;
    logic       oehi;
    logic       dn;
    int         due;
    string      req;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: push the expected output for the present model state.
  task automatic expect_now(input string req);
    exp_t e;
    logic [7:0] b;
    b      = mem_byte(m_addr);
    e.oe0  = !chip_en_n && oe_rst_n;
    e.oehi = e.oe0 && par_mode;
    e.dn   = m_done;
    if (!e.oe0) begin
      e.data = 8'h00; e.mask = 8'h00;
    end else if (par_mode) begin
      e.data = b; e.mask = 8'hFF;
    end else begin
      e.data = {7'b0, b[7 - m_bit]}; e.mask = 8'h01;
    end
    e.due = cyc;
    e.req = req;
    sb_q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare queued expectations with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (((data_out & e.mask) !== (e.data & e.mask)) || (data0_oe !== e.oe0) ||
            (data_hi_oe !== e.oehi) || (done !== e.dn)) begin
          errors++;
          $display("FAIL %s: actual data=%0h oe0=%0b oehi=%0b done=%0b expected data=%0h oe0=%0b oehi=%0b done=%0b",
                   e.req, data_out & e.mask, data0_oe, data_hi_oe, done,
                   e.data & e.mask, e.oe0, e.oehi, e.dn);
        end
      end
    end
  end

  // One external clock period; the model advances when qualified.
  task automatic ext_edge();
    bit q;
    q = !chip_en_n && oe_rst_n && cfg_pulse && !(par_mode && busy) && !m_done;
    cfg_clk_in = 1'b1;
    repeat (6) @(negedge clk);
    cfg_clk_in = 1'b0;
    repeat (6) @(negedge clk);
    if (q) begin
      if (!par_mode && m_bit != 7) m_bit++;
      else if (m_addr == rev_end(m_rev)) m_done = 1'b1;
      else begin m_addr++; m_bit = 0; end
    end
  endtask

  task automatic reload(input int r);
    cfg_pulse = 1'b0;
    repeat (4) @(negedge clk);
    rev_sel = 2'(r);
    cfg_pulse = 1'b1;
    m_rev = r; m_addr = rev_start(r); m_bit = 0; m_done = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic hold_reset_model();
    m_addr = rev_start(m_rev); m_bit = 0; m_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state with chip enable inactive
    check(done == 1'b0,       "R1", "done",       done, 0);
    check(data0_oe == 1'b0,   "R1", "data0_oe",   data0_oe, 0);
    check(data_hi_oe == 1'b0, "R1", "data_hi_oe", data_hi_oe, 0);
    check(clk_out_oe == 1'b0, "R1", "clk_out_oe", clk_out_oe, 0);
    repeat (8) @(negedge clk);
    // R11: internal divider instance not finished yet
    check(o_done == 1'b0, "R11", "osc done early", o_done, 0);

    chip_en_n = 1'b0;
    repeat (6) @(negedge clk);
    expect_now("R9");                                 // byte at address 0
    for (int i = 0; i < 4; i++) begin ext_edge(); expect_now("R2"); end

    busy = 1'b1;                                      // R3: parallel stall
    for (int i = 0; i < 2; i++) begin ext_edge(); expect_now("R3"); end
    busy = 1'b0;
    ext_edge(); expect_now("R2");

    cfg_pulse = 1'b0;                                 // R4: pulse low stalls
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) begin ext_edge(); expect_now("R4"); end
    rev_sel = 2'd2;
    cfg_pulse = 1'b1;                                 // R5: rising edge reload
    m_rev = 2; m_addr = rev_start(2); m_bit = 0; m_done = 1'b0;
    repeat (6) @(negedge clk);
    expect_now("R5");
    for (int i = 0; i < 3; i++) begin ext_edge(); expect_now("R2"); end

    chip_en_n = 1'b1;                                 // R7: standby
    hold_reset_model();
    repeat (6) @(negedge clk);
    expect_now("R7");
    for (int i = 0; i < 2; i++) begin ext_edge(); expect_now("R7"); end
    chip_en_n = 1'b0;
    repeat (6) @(negedge clk);
    expect_now("R7");

    for (int i = 0; i < 2; i++) ext_edge();
    oe_rst_n = 1'b0;                                  // R6: output-enable/reset
    hold_reset_model();
    repeat (6) @(negedge clk);
    expect_now("R6");
    ext_edge(); expect_now("R6");
    oe_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_now("R6");

    par_mode = 1'b0;                                  // R8: serial, busy ignored (R3)
    busy = 1'b1;
    reload(1);
    expect_now("R8");
    for (int i = 0; i < 12; i++) begin ext_edge(); expect_now("R8"); end
    busy = 1'b0;

    par_mode = 1'b1;                                  // R10: run to end of revision 3
    reload(3);
    expect_now("R9");
    for (int i = 0; i < 15; i++) begin ext_edge(); expect_now("R2"); end
    ext_edge(); expect_now("R10");
    for (int i = 0; i < 2; i++) begin ext_edge(); expect_now("R10"); end
    reload(0);
    expect_now("R5");

    // R11: internal divider instance finished revision 0 on its own
    check(o_done == 1'b1,       "R11", "osc done",  o_done, 1);
    check(o_data == mem_byte(15), "R11", "osc data", o_data, mem_byte(15));

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule